// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block runs one whole NAND flash operation after a single write of a control word. The operation is made of a first command byte, an optional run of address bytes, an optional data phase in either direction, and an optional closing command byte. Software loads the address, length and second-command registers first. It stages write data in an internal page buffer. It then writes the control word and polls or waits for the completion interrupt. Read data lands in the same buffer, from offset 0 upward.

The engine drives the flash strobes and the two chip enables, and holds ready/busy timing by itself. Every byte on the flash bus takes two clocks: the strobe is low for one clock and high for the next. After the last command or address byte that precedes a busy period, the engine holds off for a fixed guard interval. It then waits for the ready/busy input before it reads data or reports completion. A soft-reset register returns the engine to idle at any point.

Top module: `nand_seq`

## Requirements
- R1: A register write to the control word (index 0) with bit 31 set, while the engine is idle, starts an operation. Bits 7:0 are the first byte on the bus, latched with the command latch high. Bit 19 selects the chip enable: when it is 1, `nf_ce_no[1]` is driven low, otherwise `nf_ce_no[0]`. The other enable stays high, and both are high while idle.
- R2: When control bit 30 is set, bits 29:27 give the address cycle count minus one, for 1 to 5 cycles. When bit 30 is clear, no address bytes are issued. A count of one is always honoured.
- R3: Address bytes are taken in this order: the low and then the high byte of address register 1 (bits 15:0), then address register 2 from its low byte upward. Each is latched with the address latch high.
- R4: Control bit 26 selects a read. After the address phase, and the second command if any, the engine waits at least 4 clocks and then for ready/busy to be high. It then reads exactly the data-length number of bytes into the buffer from offset 0 upward. Read enable is never low while ready/busy is low, and a length of 0 reads nothing.
- R5: Control bit 25 selects a write. The engine sends the data-length number of bytes from buffer offset 0 upward, with both latches low, before the second command.
- R6: Second-command register bit 8 enables a closing command byte given by bits 7:0. For reads it comes after the address phase and before the data. For writes it comes after the data. With no direction bit set, it comes right after the address phase.
- R7: Interrupt register (index 5) bit 31 and `irq_o` go high when an operation completes. Writing 1 to bit 31 clears it, and writing 0 leaves it set.
- R8: Status register (index 6) bit 30 follows the ready/busy input (1 = ready). Bit 0 is 1 while an operation runs.
- R9: A control-word start written while an operation runs is ignored, and it sets sticky status bit 1.
- R10: Writing 1 to the reset register (index 7) bit 0 returns the engine to idle with pins released. It also clears the interrupt and error bits. Writing 0 releases the engine, and the next read stores from offset 0.
- R11: Write enable and read enable are never low together. Each strobe low lasts exactly one clock. Command and address latches are never high together.
- R12: Register indices 1, 2, 3 and 4 hold the second command, address 1, address 2 and the data length, and read back what was written. Bus addresses with the top bit set reach page buffer byte `addr[ADDR_W-2:0]`, which is readable and writable for all offsets below the buffer depth (2112 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register/buffer write strobe |
| reg_addr_i | input | ADDR_W | Register index or buffer offset (top bit selects buffer) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Completion interrupt |
| nf_cle_o | output | 1 | Command latch enable |
| nf_ale_o | output | 1 | Address latch enable |
| nf_we_no | output | 1 | Write enable, active low |
| nf_re_no | output | 1 | Read enable, active low |
| nf_ce_no | output | 2 | Chip enables, active low |
| nf_dq_o | output | 8 | Flash data out |
| nf_dq_oe_o | output | 1 | Flash data output enable |
| nf_dq_i | input | 8 | Flash data in |
| nf_rb_i | input | 1 | Ready/busy, 1 = ready |

## Verification
The sequencer is exercised with a five-cycle read using a start command, a one-cycle identify read on the second chip enable, a four-cycle program with data, a three-cycle erase with no data, and a bare command with no address. Together these separate the address-count decode, the byte order and the three placements of the second command. A flash model logs each latched byte and holds ready/busy low after each command, so waiting too early shows up as read strobes during busy. A zero-length read, an overlapping start, a soft reset during a hung busy wait, and interrupt writes of 0 and 1 cover the corner cases.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD1, ST_ADDR, ST_WDATA, ST_CMD2,
    ST_GUARD, ST_WAITRDY, ST_RDATA, ST_DONE
  } seq_state_e;

  localparam logic [3:0] RIX_CTRL   = 4'd0;
  localparam logic [3:0] RIX_CMD2   = 4'd1;
  localparam logic [3:0] RIX_ADDR1  = 4'd2;
  localparam logic [3:0] RIX_ADDR2  = 4'd3;
  localparam logic [3:0] RIX_LEN    = 4'd4;
  localparam logic [3:0] RIX_IRQ    = 4'd5;
  localparam logic [3:0] RIX_STATUS = 4'd6;
  localparam logic [3:0] RIX_SRST   = 4'd7;

  localparam int CW_GO    = 31;
  localparam int CW_AEN   = 30;
  localparam int CW_RD    = 26;
  localparam int CW_WR    = 25;
  localparam int CW_CE1   = 19;
endpackage

// File: rtl/nand_seq_buf.sv
module nand_seq_buf #(
  parameter int DEPTH = 2112,
  parameter int HW    = 12,
  parameter int EW    = 16
) (
  input  logic          clk_i,
  input  logic          h_we_i,
  input  logic [HW-1:0] h_idx_i,
  input  logic [7:0]    h_wdata_i,
  output logic [7:0]    h_rdata_o,
  input  logic          e_we_i,
  input  logic [EW-1:0] e_idx_i,
  input  logic [7:0]    e_wdata_i,
  output logic [7:0]    e_rdata_o
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0] mem [DEPTH];
  logic h_ok, e_ok;

  assign h_ok = int'(h_idx_i) < DEPTH;
  assign e_ok = int'(e_idx_i) < DEPTH;

  // engine port wins a same-cycle collision
  always_ff @(posedge clk_i) begin
    if (e_we_i && e_ok) mem[e_idx_i[AW-1:0]] <= e_wdata_i;
    else if (h_we_i && h_ok) mem[h_idx_i[AW-1:0]] <= h_wdata_i;
  end

  assign h_rdata_o = h_ok ? mem[h_idx_i[AW-1:0]] : 8'h00;
  assign e_rdata_o = e_ok ? mem[e_idx_i[AW-1:0]] : 8'h00;
endmodule

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
  import nand_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              rb_i,
  output logic              start_o,
  output logic              srst_o,
  output logic [8:0]        cmd2_o,
  output logic [15:0]       addr1_o,
  output logic [23:0]       addr2_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              irq_o,
  output logic              hb_we_o,
  output logic [7:0]        hb_rdata_i_unused_guard,
  input  logic [7:0]        hb_rdata_i
);
  logic             is_buf, reg_wr;
  logic [3:0]       rix;
  logic             irq_q, err_q, srst_q;
  logic [8:0]       cmd2_q;
  logic [15:0]      addr1_q;
  logic [23:0]      addr2_q;
  logic [LEN_W-1:0] len_q;
  logic             go_wr;

  assign is_buf  = reg_addr_i[ADDR_W-1];
  assign rix     = reg_addr_i[3:0];
  assign reg_wr  = reg_we_i && !is_buf;
  assign hb_we_o = reg_we_i && is_buf;
  assign go_wr   = reg_wr && rix == RIX_CTRL && reg_wdata_i[CW_GO];
  assign start_o = go_wr && !busy_i && !srst_q;
  assign hb_rdata_i_unused_guard = 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0; err_q <= 1'b0; srst_q <= 1'b0;
      cmd2_q <= '0; addr1_q <= '0; addr2_q <= '0; len_q <= '0;
    end else begin
      if (reg_wr) begin
        unique case (rix)
          RIX_CMD2:  cmd2_q  <= reg_wdata_i[8:0];
          RIX_ADDR1: addr1_q <= reg_wdata_i[15:0];
          RIX_ADDR2: addr2_q <= reg_wdata_i[23:0];
          RIX_LEN:   len_q   <= reg_wdata_i[LEN_W-1:0];
          RIX_SRST:  srst_q  <= reg_wdata_i[0];
          default: ;
        endcase
      end
      if (srst_q) begin
        irq_q <= 1'b0;
        err_q <= 1'b0;
      end else begin
        if (done_i) irq_q <= 1'b1;
        else if (reg_wr && rix == RIX_IRQ && reg_wdata_i[31]) irq_q <= 1'b0;
        if (go_wr && busy_i) err_q <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (is_buf) reg_rdata_o = {24'h0, hb_rdata_i};
    else begin
      unique case (rix)
        RIX_CMD2:   reg_rdata_o = {23'h0, cmd2_q};
        RIX_ADDR1:  reg_rdata_o = {16'h0, addr1_q};
        RIX_ADDR2:  reg_rdata_o = {8'h0, addr2_q};
        RIX_LEN:    reg_rdata_o = 32'(len_q);
        RIX_IRQ:    reg_rdata_o = {irq_q, 31'h0};
        RIX_STATUS: reg_rdata_o = {1'b0, rb_i, 28'h0, err_q, busy_i};
        RIX_SRST:   reg_rdata_o = {31'h0, srst_q};
        default:    reg_rdata_o = '0;
      endcase
    end
  end

  assign srst_o  = srst_q;
  assign cmd2_o  = cmd2_q;
  assign addr1_o = addr1_q;
  assign addr2_o = addr2_q;
  assign len_o   = len_q;
  assign irq_o   = irq_q;

  AST_IRQ_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !srst_q) |=> irq_q); // R7
  AST_OVERLAP_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_wr && busy_i && !srst_q) |=> err_q); // R9
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_seq_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int GUARD_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             start_i,
  input  logic [31:0]      ctrl_i,
  input  logic [8:0]       cmd2_i,
  input  logic [15:0]      addr1_i,
  input  logic [23:0]      addr2_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             rb_i,
  input  logic [7:0]       dq_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             cle_o,
  output logic             ale_o,
  output logic             we_no,
  output logic             re_no,
  output logic [1:0]       ce_no,
  output logic [7:0]       dq_o,
  output logic             dq_oe_o,
  output logic             bwe_o,
  output logic [LEN_W-1:0] bidx_o,
  output logic [7:0]       bwdata_o,
  input  logic [7:0]       brdata_i
);
  localparam int GW = $clog2(GUARD_CYC) + 1;

  seq_state_e       state_q, after_addr, after_wdata;
  logic             ph_q;
  logic [LEN_W-1:0] cnt_q, len_q;
  logic [GW-1:0]    gcnt_q;
  logic [7:0]       cmd1_q, cmd2_q;
  logic             c2en_q, rd_q, wr_q, ce1_q, aen_q;
  logic [2:0]       nam1_q;
  logic [39:0]      addr_q;
  logic             emit, last_byte;
  logic             unused_ctrl;

  assign unused_ctrl = ^{ctrl_i[31], ctrl_i[24:20], ctrl_i[18:8]};
  assign last_byte   = cnt_q == len_q - 1'b1;

  always_comb begin
    after_wdata = c2en_q ? ST_CMD2 : ST_GUARD;
    after_addr  = after_wdata;
    if (wr_q && len_q != '0) after_addr = ST_WDATA;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; ph_q <= 1'b0; cnt_q <= '0; gcnt_q <= '0;
      len_q <= '0; cmd1_q <= '0; cmd2_q <= '0; c2en_q <= 1'b0;
      rd_q <= 1'b0; wr_q <= 1'b0; ce1_q <= 1'b0; aen_q <= 1'b0;
      nam1_q <= '0; addr_q <= '0;
    end else if (srst_i) begin
      state_q <= ST_IDLE; ph_q <= 1'b0; cnt_q <= '0; gcnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cmd1_q <= ctrl_i[7:0];
          rd_q   <= ctrl_i[CW_RD];
          wr_q   <= ctrl_i[CW_WR];
          ce1_q  <= ctrl_i[CW_CE1];
          aen_q  <= ctrl_i[CW_AEN];
          nam1_q <= ctrl_i[29:27];
          cmd2_q <= cmd2_i[7:0];
          c2en_q <= cmd2_i[8];
          addr_q <= {addr2_i, addr1_i};
          len_q  <= len_i;
          cnt_q  <= '0;
          ph_q   <= 1'b0;
          state_q <= ST_CMD1;
        end
        ST_CMD1: begin
          ph_q <= ~ph_q;
          if (ph_q) state_q <= aen_q ? ST_ADDR : after_addr;
        end
        ST_ADDR: begin
          ph_q <= ~ph_q;
          if (ph_q) begin
            if (cnt_q[2:0] == nam1_q) begin
              cnt_q <= '0;
              state_q <= after_addr;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WDATA: begin
          ph_q <= ~ph_q;
          if (ph_q) begin
            if (last_byte) begin
              cnt_q <= '0;
              state_q <= after_wdata;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_CMD2: begin
          ph_q <= ~ph_q;
          if (ph_q) state_q <= ST_GUARD;
        end
        ST_GUARD: begin
          if (gcnt_q == GW'(GUARD_CYC - 1)) begin
            gcnt_q <= '0;
            state_q <= ST_WAITRDY;
          end else gcnt_q <= gcnt_q + 1'b1;
        end
        ST_WAITRDY: if (rb_i) begin
          cnt_q <= '0;
          ph_q  <= 1'b0;
          state_q <= (rd_q && len_q != '0) ? ST_RDATA : ST_DONE;
        end
        ST_RDATA: begin
          ph_q <= ~ph_q;
          if (ph_q) begin
            if (last_byte) state_q <= ST_DONE;
            else cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cle_o   = state_q == ST_CMD1 || state_q == ST_CMD2;
    ale_o   = state_q == ST_ADDR;
    emit    = cle_o || ale_o || state_q == ST_WDATA;
    we_no   = !(emit && !ph_q);
    re_no   = !(state_q == ST_RDATA && !ph_q);
    dq_oe_o = emit;
    busy_o  = state_q != ST_IDLE;
    done_o  = state_q == ST_DONE;
    ce_no   = !busy_o ? 2'b11 : (ce1_q ? 2'b01 : 2'b10);
    unique case (state_q)
      ST_CMD1:  dq_o = cmd1_q;
      ST_ADDR:  dq_o = addr_q[{cnt_q[2:0], 3'b000} +: 8];
      ST_WDATA: dq_o = brdata_i;
      ST_CMD2:  dq_o = cmd2_q;
      default:  dq_o = 8'h00;
    endcase
  end

  assign bwe_o    = state_q == ST_RDATA && !ph_q;
  assign bidx_o   = cnt_q;
  assign bwdata_o = dq_i;

  AST_WE_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |=> we_no); // R11
  AST_RE_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |=> re_no); // R11
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAITRDY && !rb_i && !srst_i) |=> state_q == ST_WAITRDY); // R4
  AST_READ_AFTER_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_RDATA) |-> $past(rb_i)); // R4
  AST_SRST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> state_q == ST_IDLE); // R10
endmodule

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int BUF_DEPTH = 2112,
  parameter int ADDR_W    = 13,
  parameter int LEN_W     = 16,
  parameter int GUARD_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic              nf_cle_o,
  output logic              nf_ale_o,
  output logic              nf_we_no,
  output logic              nf_re_no,
  output logic [1:0]        nf_ce_no,
  output logic [7:0]        nf_dq_o,
  output logic              nf_dq_oe_o,
  input  logic [7:0]        nf_dq_i,
  input  logic              nf_rb_i
);
  localparam int HW = ADDR_W - 1;

  logic             busy, done, start, srst;
  logic [8:0]       cmd2;
  logic [15:0]      addr1;
  logic [23:0]      addr2;
  logic [LEN_W-1:0] len;
  logic             hb_we, eb_we;
  logic [7:0]       hb_rdata, eb_rdata, eb_wdata;
  logic [7:0]       unused_guard;
  logic [LEN_W-1:0] eb_idx;

  nand_seq_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .done_i(done), .rb_i(nf_rb_i),
    .start_o(start), .srst_o(srst), .cmd2_o(cmd2), .addr1_o(addr1),
    .addr2_o(addr2), .len_o(len), .irq_o,
    .hb_we_o(hb_we), .hb_rdata_i_unused_guard(unused_guard), .hb_rdata_i(hb_rdata)
  );

  nand_seq_fsm #(.LEN_W(LEN_W), .GUARD_CYC(GUARD_CYC)) u_fsm (
    .clk_i, .rst_ni, .srst_i(srst), .start_i(start), .ctrl_i(reg_wdata_i),
    .cmd2_i(cmd2), .addr1_i(addr1), .addr2_i(addr2), .len_i(len),
    .rb_i(nf_rb_i), .dq_i(nf_dq_i), .busy_o(busy), .done_o(done),
    .cle_o(nf_cle_o), .ale_o(nf_ale_o), .we_no(nf_we_no), .re_no(nf_re_no),
    .ce_no(nf_ce_no), .dq_o(nf_dq_o), .dq_oe_o(nf_dq_oe_o),
    .bwe_o(eb_we), .bidx_o(eb_idx), .bwdata_o(eb_wdata), .brdata_i(eb_rdata)
  );

  nand_seq_buf #(.DEPTH(BUF_DEPTH), .HW(HW), .EW(LEN_W)) u_buf (
    .clk_i, .h_we_i(hb_we), .h_idx_i(reg_addr_i[HW-1:0]),
    .h_wdata_i(reg_wdata_i[7:0]), .h_rdata_o(hb_rdata),
    .e_we_i(eb_we), .e_idx_i(eb_idx), .e_wdata_i(eb_wdata), .e_rdata_o(eb_rdata)
  );
endmodule

// File: tb/nand_seq_tb.sv
module nand_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_CYC   = 20;
  localparam logic [12:0] BUFB = 13'h1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [12:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, cle, ale, we_n, re_n, dq_oe, rb;
  logic [1:0] ce_n;
  logic [7:0] dq_o, dq_i;

  int checks = 0, errors = 0;
  int busy_cnt = 0, rd_idx = 0;
  logic rb_hold = 1'b0, mon_en = 1'b0, re_seen = 1'b0;
  logic [1:0] ce_low = 2'b00;
  int evq[$], expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .nf_cle_o(cle), .nf_ale_o(ale), .nf_we_no(we_n), .nf_re_no(re_n),
    .nf_ce_no(ce_n), .nf_dq_o(dq_o), .nf_dq_oe_o(dq_oe), .nf_dq_i(dq_i),
    .nf_rb_i(rb)
  );

  // flash model
  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction
  assign rb   = (busy_cnt == 0) && !rb_hold;
  assign dq_i = pat(rd_idx);
  always @(posedge we_n) begin
    evq.push_back({22'h0, cle, ale, dq_o});
    if (cle) begin busy_cnt = BUSY_CYC; rd_idx = 0; end
  end
  always @(posedge re_n) rd_idx++;
  always @(posedge clk) if (busy_cnt > 0) busy_cnt--;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // per-clock pin protocol reference
  always @(negedge clk) if (mon_en) begin
    chk("R11 cle/ale exclusive", 32'(cle && ale), 0);
    chk("R11 we/re exclusive", 32'(!we_n && !re_n), 0);
    chk("R4 no read strobe while busy", 32'(!re_n && !rb), 0);
    chk("R1 at most one chip enable", 32'(ce_n == 2'b00), 0);
    ce_low |= ~ce_n;
    if (!re_n) re_seen = 1'b1;
  end

  task automatic wr(logic [12:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic rd(logic [12:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] mk(logic [7:0] c, bit r, bit w, bit c1, int na);
    logic [31:0] v = 32'h8000_0000 | 32'(c);
    if (r) v[26] = 1'b1;
    if (w) v[25] = 1'b1;
    if (c1) v[19] = 1'b1;
    if (na > 0) v[30:27] = 4'(((na - 1) | 8));
    return v;
  endfunction

  task automatic setup(logic [8:0] c2, logic [15:0] a1, logic [23:0] a2, int len);
    wr(13'd1, 32'(c2)); wr(13'd2, 32'(a1)); wr(13'd3, 32'(a2)); wr(13'd4, 32'(len));
    evq.delete(); ce_low = 2'b00; re_seen = 1'b0;
  endtask

  task automatic wait_irq(string req);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(13'd5, v);
      if (v[31]) return;
    end
    chk(req, 0, 32'h8000_0000);
  endtask

  task automatic build_exp(logic [7:0] c, int na, logic [15:0] a1, logic [23:0] a2,
                           bit w, int len, logic [8:0] c2);
    logic [39:0] ab = {a2, a1};
    expq.delete();
    expq.push_back(32'h200 | 32'(c));
    for (int k = 0; k < na; k++) expq.push_back(32'h100 | 32'(ab[8*k +: 8]));
    if (w) for (int k = 0; k < len; k++) expq.push_back(32'(8'hA0 + k));
    if (c2[8]) expq.push_back(32'h200 | 32'(c2[7:0]));
  endtask

  task automatic cmp_events(string req);
    chk({req, " event count"}, 32'(evq.size()), 32'(expq.size()));
    for (int k = 0; k < expq.size() && k < evq.size(); k++)
      chk({req, " bus byte"}, 32'(evq[k]), 32'(expq[k]));
  endtask

  task automatic chk_buf(string req, int len);
    logic [31:0] v;
    for (int k = 0; k < len; k++) begin
      rd(BUFB + 13'(k), v);
      chk(req, v, 32'(pat(k)));
    end
  endtask

  task automatic chk_idle_pins(string req);
    @(negedge clk);
    chk(req, {25'h0, cle, ale, we_n, re_n, ce_n, dq_oe}, {25'h0, 7'b0011110});
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R1 watchdog act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    evq.delete();
    // reset state
    chk_idle_pins("R1 idle pins after reset");
    rd(13'd6, v); chk("R8 status after reset", v, 32'h4000_0000);
    rd(13'd5, v); chk("R7 irq clear after reset", v, 0);
    mon_en = 1'b1;

    // R12 register and buffer window
    wr(13'd4, 32'h0000_1234); rd(13'd4, v); chk("R12 length readback", v, 32'h1234);
    wr(BUFB + 13'd2111, 32'h0000_00C3); rd(BUFB + 13'd2111, v); chk("R12 last buffer byte", v, 32'hC3);

    // R2 R3 R4 R6: five-cycle page read with start command
    setup(9'h130, 16'h1234, 24'h056789, 6);
    wr(13'd0, mk(8'h00, 1, 0, 0, 5));
    rd(13'd6, v); chk("R8 busy bit during operation", 32'(v[0]), 1);
    wait_irq("R7 page read completion");
    chk("R7 irq_o high", 32'(irq), 1);
    build_exp(8'h00, 5, 16'h1234, 24'h056789, 0, 0, 9'h130);
    cmp_events("R3 page read");
    chk("R1 chip enable 0 only", 32'(ce_low), 2'b01);
    chk_buf("R4 page read data", 6);
    wr(13'd5, 32'h0);          rd(13'd5, v); chk("R7 write 0 keeps irq", v, 32'h8000_0000);
    wr(13'd5, 32'h8000_0000);  rd(13'd5, v); chk("R7 write 1 clears irq", v, 0);

    // R2 single address cycle identify read on CE1
    setup(9'h000, 16'h0000, 24'h0, 4);
    wr(13'd0, mk(8'h90, 1, 0, 1, 1));
    wait_irq("R2 identify completion");
    build_exp(8'h90, 1, 16'h0, 24'h0, 0, 0, 9'h000);
    cmp_events("R2 identify");
    chk("R1 chip enable 1 only", 32'(ce_low), 2'b10);
    chk_buf("R4 identify data", 4);
    wr(13'd5, 32'h8000_0000);

    // R5 R6 program with data then confirm
    for (int k = 0; k < 5; k++) wr(BUFB + 13'(k), 32'(8'hA0 + k));
    setup(9'h110, 16'h0040, 24'h000123, 5);
    wr(13'd0, mk(8'h80, 0, 1, 0, 4));
    wait_irq("R5 program completion");
    build_exp(8'h80, 4, 16'h0040, 24'h000123, 1, 5, 9'h110);
    cmp_events("R5 program");
    chk("R4 no read strobe on program", 32'(re_seen), 0);
    wr(13'd5, 32'h8000_0000);

    // R6 erase: no data, second command after address
    setup(9'h1D0, 16'h5678, 24'h000009, 0);
    wr(13'd0, mk(8'h60, 0, 0, 0, 3));
    wait_irq("R6 erase completion");
    build_exp(8'h60, 3, 16'h5678, 24'h000009, 0, 0, 9'h1D0);
    cmp_events("R6 erase");
    wr(13'd5, 32'h8000_0000);

    // R2 no address phase
    setup(9'h000, 16'hFFFF, 24'hFFFFFF, 0);
    wr(13'd0, mk(8'hFF, 0, 0, 0, 0));
    wait_irq("R2 bare command completion");
    build_exp(8'hFF, 0, 16'h0, 24'h0, 0, 0, 9'h000);
    cmp_events("R2 bare command");
    wr(13'd5, 32'h8000_0000);

    // R4 zero-length read stores nothing
    wr(BUFB, 32'h5A);
    setup(9'h000, 16'h0000, 24'h0, 0);
    wr(13'd0, mk(8'h70, 1, 0, 0, 1));
    wait_irq("R4 zero length completion");
    chk("R4 zero length: no read strobe", 32'(re_seen), 0);
    rd(BUFB, v); chk("R4 zero length: buffer untouched", v, 32'h5A);
    wr(13'd5, 32'h8000_0000);

    // R9 overlapping start ignored, sticky error
    setup(9'h130, 16'h0002, 24'h000001, 3);
    wr(13'd0, mk(8'h00, 1, 0, 0, 5));
    wr(13'd0, mk(8'hEE, 0, 0, 1, 1));
    wait_irq("R9 first op completion");
    build_exp(8'h00, 5, 16'h0002, 24'h000001, 0, 0, 9'h130);
    cmp_events("R9 second start ignored");
    chk("R9 chip enable unchanged", 32'(ce_low), 2'b01);
    rd(13'd6, v); chk("R9 sticky error bit", 32'(v[1]), 1);
    repeat (40) @(negedge clk);
    rd(13'd6, v); chk("R9 error stays set", 32'(v[1]), 1);

    // R8 status follows ready/busy
    rb_hold = 1'b1; rd(13'd6, v); chk("R8 busy seen", 32'(v[30]), 0);
    rb_hold = 1'b0; rd(13'd6, v); chk("R8 ready seen", 32'(v[30]), 1);

    // R10 soft reset during a hung busy wait (irq still set from previous op)
    rb_hold = 1'b1;
    setup(9'h130, 16'h0, 24'h0, 8);
    wr(13'd0, mk(8'h00, 1, 0, 0, 5));
    repeat (60) @(negedge clk);
    rd(13'd6, v); chk("R10 engine hung busy", 32'(v[0]), 1);
    wr(13'd7, 32'h1);
    rd(13'd6, v); chk("R10 soft reset idle, error cleared", v & 32'h3, 0);
    rd(13'd5, v); chk("R10 soft reset clears irq", v, 0);
    chk_idle_pins("R10 pins released");
    wr(13'd7, 32'h0);
    rb_hold = 1'b0;
    setup(9'h130, 16'h0, 24'h0, 3);
    wr(13'd0, mk(8'h00, 1, 0, 0, 5));
    wait_irq("R10 op after soft reset");
    chk_buf("R10 buffer pointer restarted at 0", 3);
    wr(13'd5, 32'h8000_0000);
    chk_idle_pins("R11 pins idle at end");

    mon_en = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule